// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the mode sequencer of a LIN physical-layer interface. It tracks one of four modes: sleep, power-on, standby and normal. From that mode it drives the digital enables that stand in for the analog parts: regulator inhibit, slave termination, transmitter permission, the level presented on the receive-data pin and the strong pull-down on the transmit-data pin. All of its inputs are synchronous digital levels or one-cycle strobes. These are the sleep-control level after debouncing, the local and remote wake strobes from a separate detector, a supply-above-reset level, a low-battery level, the transmit-data level and the filtered bus level.

A mode change requested by the host takes effect only after the sleep-control level has stayed steady for a set number of clock cycles. A wake event seen in sleep moves the block to standby by itself. Standby raises an interrupt on the receive-data output and records whether the wake came from the local input or from the bus. Both indications clear on the first cycle after sleep-control rises, well before the delayed switch to normal mode.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is applied, and afterwards while supply-ok stays low, the mode is sleep (mode code 0). Inhibit, termination, transmitter permission and the strong pull-down are all 0, and the receive-data output is 1 (released).
- R2: On the first clock where supply-ok is 1 after having been 0, the mode becomes power-on (code 1). Inhibit and termination are 1, transmitter permission is 0 and receive-data is 1.
- R3: From sleep, power-on or standby, the mode becomes normal (code 3) at the clock edge that samples sleep-control high for the NORM_CYC-th consecutive time. A single low sample restarts the count.
- R4: From normal, the mode becomes sleep at the clock edge that samples sleep-control low for the SLEEP_CYC-th consecutive time. A single high sample restarts the count.
- R5: In sleep, inhibit, termination and transmitter permission are 0 and receive-data is 1. Entering sleep does not depend on the transmit-data level or the bus level.
- R6: A local or remote wake strobe sampled in sleep moves the mode to standby (code 2) on that edge. Inhibit and termination go to 1 and receive-data goes to 0.
- R7: In standby, the strong pull-down output is 1 if the wake came from the local strobe and 0 if it came from the remote strobe. The local strobe wins when both arrive together.
- R8: The edge that first samples sleep-control high after a low sample clears the receive-data interrupt and the strong pull-down. The mode stays standby until R3 is met.
- R9: Whenever supply-ok is sampled low, the mode is sleep after that edge, whatever mode it was in before.
- R10: Transmitter permission is 1 only in normal mode, and only after transmit-data has been sampled high since normal mode was entered. Low-battery forces it to 0 at once. After low-battery clears, transmit-data must be sampled high again before permission returns.
- R11: In normal mode, receive-data follows the filtered bus level: 1 for recessive, 0 for dominant.
- R12: Wake strobes sampled in power-on, standby or normal mode do not change the mode or any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slp_i | input | 1 | Debounced sleep-control level, 1 requests normal |
| wake_local_i | input | 1 | One-cycle local wake strobe |
| wake_remote_i | input | 1 | One-cycle remote (bus) wake strobe |
| por_ok_i | input | 1 | Supply above power-on-reset threshold |
| bat_low_i | input | 1 | Supply below driver undervoltage threshold |
| txd_i | input | 1 | Transmit-data level from the protocol controller |
| bus_rx_i | input | 1 | Filtered bus level, 1 recessive |
| mode_o | output | 2 | Mode: 0 sleep, 1 power-on, 2 standby, 3 normal |
| inh_en_o | output | 1 | Regulator inhibit enable |
| term_en_o | output | 1 | Slave termination enable |
| tx_allow_o | output | 1 | Transmitter permitted to drive |
| rxd_o | output | 1 | Receive-data pin level, 0 pulls low |
| txd_pd_strong_o | output | 1 | Strong pull-down on transmit-data (local wake source) |

## Verification
The hardest state to reach is standby with its flags already cleared by a sleep-control rising edge but without the normal-entry count having completed. The stimulus gets there with a sleep-control pulse shorter than NORM_CYC. It then drops the level, confirms that the interrupt and the source indication are gone while the mode is unchanged, and only afterwards holds the level long enough to enter normal. Hold windows one sample short of their limit, with a one-cycle opposite glitch, check the restart of both timers. A low-battery pulse with transmit-data held low checks that transmit permission waits for re-arming.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    M_SLEEP = 2'd0,
    M_PWRON = 2'd1,
    M_STBY  = 2'd2,
    M_NORM  = 2'd3
  } lin_mode_e;
endpackage

// File: rtl/lin_hold_timer.sv
module lin_hold_timer #(
  parameter int unsigned LIM = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic hit_o
);
  localparam int unsigned W = $clog2(LIM + 1);
  localparam logic [W-1:0] TOP = W'(LIM - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!lvl_i)      cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  // fires on the edge that samples the LIM-th consecutive active level
  assign hit_o = lvl_i && (cnt_q == TOP);

  AST_HIT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(lvl_i)); // R3
endmodule

// File: rtl/lin_tx_gate.sv
module lin_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_norm_i,
  input  logic txd_i,
  input  logic bat_low_i,
  output logic tx_allow_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (!in_norm_i) armed_q <= 1'b0;
    else if (bat_low_i)  armed_q <= 1'b0;
    else if (txd_i)      armed_q <= 1'b1;
  end

  assign tx_allow_o = in_norm_i && armed_q && !bat_low_i;

  AST_ARM_NEEDS_TXD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_allow_o) |-> $past(txd_i)); // R10
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int unsigned NORM_CYC  = 1250,
  parameter int unsigned SLEEP_CYC = 1250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slp_i,
  input  logic       wake_local_i,
  input  logic       wake_remote_i,
  input  logic       por_ok_i,
  input  logic       bat_low_i,
  input  logic       txd_i,
  input  logic       bus_rx_i,
  output logic [1:0] mode_o,
  output logic       inh_en_o,
  output logic       term_en_o,
  output logic       tx_allow_o,
  output logic       rxd_o,
  output logic       txd_pd_strong_o
);
  lin_mode_e mode_q, mode_d;
  logic slp_q, por_q, req_q, loc_q;
  logic norm_hit, sleep_hit, slp_rise, por_rise, enter_stby, flag_clr;

  lin_hold_timer #(.LIM(NORM_CYC)) u_norm_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(slp_i), .hit_o(norm_hit));

  lin_hold_timer #(.LIM(SLEEP_CYC)) u_sleep_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(!slp_i), .hit_o(sleep_hit));

  assign slp_rise = slp_i && !slp_q;
  assign por_rise = por_ok_i && !por_q;

  always_comb begin
    mode_d = mode_q;
    if (!por_ok_i)     mode_d = M_SLEEP;
    else if (por_rise) mode_d = M_PWRON;
    else begin
      unique case (mode_q)
        M_SLEEP: begin
          if (norm_hit)                          mode_d = M_NORM;
          else if (wake_local_i || wake_remote_i) mode_d = M_STBY;
        end
        M_PWRON, M_STBY: if (norm_hit) mode_d = M_NORM;
        M_NORM:          if (sleep_hit) mode_d = M_SLEEP;
        default:         mode_d = M_SLEEP;
      endcase
    end
  end

  assign enter_stby = (mode_d == M_STBY) && (mode_q != M_STBY);
  assign flag_clr   = !por_ok_i || slp_rise || (mode_d == M_NORM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_SLEEP;
      slp_q  <= 1'b0;
      por_q  <= 1'b0;
      req_q  <= 1'b0;
      loc_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      slp_q  <= slp_i;
      por_q  <= por_ok_i;
      if (flag_clr) begin
        req_q <= 1'b0;
        loc_q <= 1'b0;
      end else if (enter_stby) begin
        req_q <= 1'b1;
        loc_q <= wake_local_i;
      end
    end
  end

  lin_tx_gate u_tx_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_norm_i(mode_q == M_NORM),
    .txd_i(txd_i), .bat_low_i(bat_low_i), .tx_allow_o(tx_allow_o));

  assign mode_o          = mode_q;
  assign inh_en_o        = (mode_q != M_SLEEP);
  assign term_en_o       = (mode_q != M_SLEEP);
  assign txd_pd_strong_o = (mode_q == M_STBY) && loc_q;

  always_comb begin
    unique case (mode_q)
      M_NORM:  rxd_o = bus_rx_i;
      M_STBY:  rxd_o = !req_q;
      default: rxd_o = 1'b1;
    endcase
  end

  AST_POR_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> (mode_q == M_SLEEP)); // R9
  AST_NORM_NEEDS_SLP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_NORM && $past(mode_q) != M_NORM) |-> $past(slp_i)); // R3
  AST_STBY_FROM_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_STBY && $past(mode_q) != M_STBY) |-> ($past(mode_q) == M_SLEEP)); // R6
  AST_RISE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slp_rise |=> (rxd_o || mode_q == M_NORM) && !txd_pd_strong_o); // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SLEEP) |-> !tx_allow_o); // R5
endmodule

// File: tb/sim_lin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lin_mode_ctrl;
  localparam int NORM = 8;
  localparam int SLP  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp = 0, wl = 0, wr = 0, por = 0, bat = 0, txd = 0, bus = 1;
  logic [1:0] mode;
  logic inh, term, txa, rxd, pds;

  int checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  lin_mode_ctrl #(.NORM_CYC(NORM), .SLEEP_CYC(SLP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slp_i(slp), .wake_local_i(wl),
    .wake_remote_i(wr), .por_ok_i(por), .bat_low_i(bat), .txd_i(txd),
    .bus_rx_i(bus), .mode_o(mode), .inh_en_o(inh), .term_en_o(term),
    .tx_allow_o(txa), .rxd_o(rxd), .txd_pd_strong_o(pds));

  // behavioural reference
  int m_mode = 0, m_hi = 0, m_lo = 0;
  bit m_req = 0, m_loc = 0, m_arm = 0, m_slp_p = 0, m_por_p = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_hi = 0; m_lo = 0; m_req = 0; m_loc = 0;
      m_arm = 0; m_slp_p = 0; m_por_p = 0;
    end else begin
      int nm;
      bit rise, prise, nok, sok;
      m_hi = slp ? (m_hi < 100000 ? m_hi + 1 : m_hi) : 0;
      m_lo = !slp ? (m_lo < 100000 ? m_lo + 1 : m_lo) : 0;
      nok = m_hi >= NORM;
      sok = m_lo >= SLP;
      rise = slp && !m_slp_p;
      prise = por && !m_por_p;
      m_arm = (m_mode == 3) ? (bat ? 1'b0 : (txd ? 1'b1 : m_arm)) : 1'b0;
      nm = m_mode;
      if (!por) nm = 0;
      else if (prise) nm = 1;
      else if (m_mode == 0) begin
        if (nok) nm = 3;
        else if (wl || wr) nm = 2;
      end else if (m_mode == 3) begin
        if (sok) nm = 0;
      end else if (nok) nm = 3;
      if (nm == 2 && m_mode != 2) begin m_req = 1; m_loc = wl; end
      if (!por || rise || nm == 3) begin m_req = 0; m_loc = 0; end
      m_mode = nm;
      m_slp_p = slp;
      m_por_p = por;
    end
  end

  function automatic bit exp_rxd();
    if (m_mode == 3) return bus;
    if (m_mode == 2) return !m_req;
    return 1'b1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "mode", mode, m_mode);
      chk(cur_req, "inh", inh, m_mode != 0);
      chk(cur_req, "term", term, m_mode != 0);
      chk(cur_req, "tx_allow", txa, (m_mode == 3) && m_arm && !bat);
      chk(cur_req, "rxd", rxd, exp_rxd());
      chk(cur_req, "pd_strong", pds, (m_mode == 2) && m_loc);
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  initial begin
    tick(3);
    look();
    chk("R1", "mode in reset", mode, 0);
    chk("R1", "inh in reset", inh, 0);
    chk("R1", "rxd in reset", rxd, 1);
    rst_n = 1; tick(3); look();
    chk("R1", "mode after reset", mode, 0);
    chk("R1", "tx_allow after reset", txa, 0);

    cur_req = "R2"; por = 1; tick(1); look();
    chk("R2", "power-on mode", mode, 1);
    chk("R2", "power-on inh", inh, 1);
    chk("R2", "power-on tx_allow", txa, 0);

    cur_req = "R12"; wr = 1; tick(1); wr = 0; tick(1); look();
    chk("R12", "wake in power-on ignored", mode, 1);

    cur_req = "R3"; slp = 1; tick(NORM - 1); slp = 0; tick(1); look();
    chk("R3", "short hold stays power-on", mode, 1);
    slp = 1; tick(NORM - 1); look();
    chk("R3", "one short of limit", mode, 1);
    tick(1); look();
    chk("R3", "normal after full hold", mode, 3);

    cur_req = "R10"; txd = 0; tick(3); look();
    chk("R10", "tx blocked while txd low", txa, 0);
    txd = 1; tick(1); look();
    chk("R10", "tx allowed after txd high", txa, 1);
    bat = 1; #0.5; chk("R10", "low battery drops tx at once", txa, 0);
    txd = 0; tick(2); bat = 0; tick(2); look();
    chk("R10", "tx stays off until txd high", txa, 0);
    txd = 1; tick(1); look();
    chk("R10", "tx re-armed", txa, 1);

    cur_req = "R11"; bus = 0; look();
    chk("R11", "rxd follows dominant", rxd, 0);
    bus = 1; tick(1); look();
    chk("R11", "rxd follows recessive", rxd, 1);

    cur_req = "R12"; wl = 1; tick(1); wl = 0; look();
    chk("R12", "local wake in normal ignored", mode, 3);

    cur_req = "R4"; slp = 0; tick(SLP - 1); slp = 1; tick(1); slp = 0; look();
    chk("R4", "glitch restarts sleep count", mode, 3);
    cur_req = "R5"; txd = 0; bus = 0; tick(SLP); look();
    chk("R5", "sleep entered with txd low, bus dominant", mode, 0);
    chk("R5", "sleep inh", inh, 0);
    chk("R5", "sleep rxd released", rxd, 1);
    bus = 1;

    cur_req = "R6"; tick(2); wr = 1; tick(1); wr = 0; look();
    chk("R6", "remote wake to standby", mode, 2);
    chk("R6", "standby interrupt", rxd, 0);
    chk("R7", "remote source weak", pds, 0);

    cur_req = "R8"; slp = 1; tick(1); slp = 0; look();
    chk("R8", "interrupt cleared on rise", rxd, 1);
    chk("R8", "mode still standby", mode, 2);
    tick(2);
    cur_req = "R3"; slp = 1; tick(NORM); look();
    chk("R3", "standby to normal", mode, 3);
    cur_req = "R4"; slp = 0; tick(SLP); look();
    chk("R4", "normal to sleep", mode, 0);

    cur_req = "R7"; tick(1); wl = 1; wr = 1; tick(1); wl = 0; wr = 0; look();
    chk("R7", "local wins, strong pull-down", pds, 1);
    cur_req = "R12"; wr = 1; tick(1); wr = 0; look();
    chk("R12", "wake in standby keeps source", pds, 1);
    cur_req = "R8"; slp = 1; tick(1); look();
    chk("R8", "strong pull-down cleared", pds, 0);
    chk("R8", "standby kept before hold", mode, 2);
    tick(NORM); look();
    chk("R3", "normal after continued hold", mode, 3);

    cur_req = "R9"; por = 0; tick(1); look();
    chk("R9", "supply loss to sleep", mode, 0);
    cur_req = "R2"; por = 1; tick(1); look();
    chk("R2", "power-on again", mode, 1);
    tick(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule